// File: doc/BRIEF.md
# Endpoint Status Register Bank

This block holds an eight-bit status word for each endpoint of a USB device controller. With the default of 16 endpoints, index 0 is control OUT, index 1 is control IN, and indices 2 to 15 are endpoints 1 to 14. The protocol engine updates the flags through per-endpoint event strobes. Each strobe lasts one cycle and arrives as one bit of a vector indexed by endpoint. The flags are: stall, the two buffer-full flags, the data PID of the next packet, a setup-overwrite flag, a setup-received flag and a CPU buffer select. Each endpoint also drives an interrupt line.

A host CPU reads a status word in two phases over a parallel port. In the first phase it writes a command byte with the address line high. In the second phase it reads with the address line low. A status read clears that endpoint's pending interrupt and its setup-related flags. When a setup token arrives, the endpoint leaves the stalled state on its own.

Top module: `ep_status_bank`

## Requirements
- R1: After reset every status bit, every `irq` line and `hp_rdata` are 0, and no endpoint is selected.
- R2: A write with `hp_a0`=1 and code 50h+n on `hp_cmd` selects endpoint n. The next read with `hp_a0`=0 returns that endpoint's status on `hp_rdata[7:0]` one cycle after the read strobe, with the upper bits 0. The output holds until the next read.
- R3: Status layout: bit 7 stall, bit 6 secondary buffer full, bit 5 primary buffer full, bit 4 next data PID (1 = DATA1), bit 3 setup overwritten, bit 2 setup received, bit 1 CPU buffer select, bit 0 always 0.
- R4: `ev_stall` sets the stall bit and `ev_unstall` clears it. If both arrive in the same cycle, the stall bit ends up set.
- R5: `ev_setup` clears stall unless `ev_stall` arrives in the same cycle. It also forces the PID bit to 1 and sets setup-received. If setup-received is already 1 when `ev_setup` arrives, the overwrite bit is set.
- R6: `ev_xfer_ok` toggles the PID bit, unless `ev_setup` arrives in the same cycle.
- R7: `ev_fill_pri`/`ev_fill_sec` set the primary/secondary full bits, and `ev_empty_pri`/`ev_empty_sec` clear them. A fill wins over an empty in the same cycle.
- R8: `irq[n]` is set one cycle after `ev_setup[n]` or `ev_xfer_ok[n]`. A status read of endpoint n clears `irq[n]`, the setup-received bit and the overwrite bit, and leaves other endpoints unchanged. A set event in the same cycle as the read wins.
- R9: A command code outside 50h..5Fh changes no status and cancels any selection. A read with no valid selection returns 00h and clears nothing.
- R10: One selection serves exactly one read. A second read with no new command returns 00h.
- R11: `ev_buf_swap` toggles the CPU buffer select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_wr | input | 1 | Host write strobe |
| hp_rd | input | 1 | Host read strobe |
| hp_a0 | input | 1 | Phase select: 1 command, 0 data |
| hp_cmd | input | 8 | Command code (low data byte) |
| hp_rdata | output | 16 | Read data, status in bits 7:0 |
| ev_stall | input | 16 | Stall command per endpoint |
| ev_unstall | input | 16 | Unstall command per endpoint |
| ev_setup | input | 16 | Setup token received per endpoint |
| ev_xfer_ok | input | 16 | Successful transaction per endpoint |
| ev_fill_pri | input | 16 | Primary buffer filled |
| ev_fill_sec | input | 16 | Secondary buffer filled |
| ev_empty_pri | input | 16 | Primary buffer emptied |
| ev_empty_sec | input | 16 | Secondary buffer emptied |
| ev_buf_swap | input | 16 | CPU buffer select toggle |
| irq | output | 16 | Per-endpoint interrupt |

## Verification
A flag in the wrong state stays hidden until the host reads that endpoint. It then appears in `hp_rdata` one cycle after the read strobe. Interrupt corruption is different: `irq` shows it one cycle after the event or read that caused it. A bad selection latch shows up as status from the wrong endpoint, or as a missing 00h on a read with no valid selection. Lost read-clears, or read-clears applied to the wrong endpoint, show up on `irq` and in the next read of either endpoint. So the reference model is compared on `irq` and `hp_rdata` every cycle.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;

   // Packed MSB-first so that the struct is the status byte as read.
   typedef struct packed {
      logic stall;
      logic full_sec;
      logic full_pri;
      logic pid;
      logic ovr;
      logic setup;
      logic cpubuf;
      logic rsvd;
   } ep_stat_t;

   localparam int STAT_W = $bits(ep_stat_t);

endpackage

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode #(
   parameter int NUM_EP   = 16,
   parameter int CMD_BASE = 8'h50,
   localparam int SEL_W   = $clog2(NUM_EP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hp_wr,
   input  logic             hp_rd,
   input  logic             hp_a0,
   input  logic [7:0]       hp_cmd,
   output logic [SEL_W-1:0] sel,
   output logic             data_rd,
   output logic             rd_fire
);
   localparam logic [7:0] BASE_B = 8'(CMD_BASE);

   logic       armed;
   logic       cmd_wr;
   logic       hit;
   logic [8:0] offs;

   assign cmd_wr  = hp_wr & hp_a0;
   assign data_rd = hp_rd & ~hp_a0 & ~cmd_wr;
   assign offs    = {1'b0, hp_cmd} - {1'b0, BASE_B};
   assign hit     = (hp_cmd >= BASE_B) && (offs < 9'(NUM_EP));
   assign rd_fire = data_rd & armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         sel   <= '0;
      end else if (cmd_wr) begin
         armed <= hit;
         if (hit) sel <= offs[SEL_W-1:0];
      end else if (data_rd) begin
         armed <= 1'b0;
      end
   end

endmodule

// File: rtl/ep_stat_cell.sv
module ep_stat_cell
   import ep_stat_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ev_stall,
   input  logic     ev_unstall,
   input  logic     ev_setup,
   input  logic     ev_xfer_ok,
   input  logic     ev_fill_pri,
   input  logic     ev_fill_sec,
   input  logic     ev_empty_pri,
   input  logic     ev_empty_sec,
   input  logic     ev_buf_swap,
   input  logic     rd_clr,
   output ep_stat_t st,
   output logic     irq
);
   ep_stat_t st_n;
   logic     irq_n;

   always_comb begin
      st_n = st;
      // stall: an explicit stall command outranks both clear sources
      if (ev_stall)                     st_n.stall = 1'b1;
      else if (ev_unstall || ev_setup)  st_n.stall = 1'b0;
      // buffer-full flags: fill outranks empty
      if (ev_fill_pri)       st_n.full_pri = 1'b1;
      else if (ev_empty_pri) st_n.full_pri = 1'b0;
      if (ev_fill_sec)       st_n.full_sec = 1'b1;
      else if (ev_empty_sec) st_n.full_sec = 1'b0;
      // data PID: setup forces DATA1, otherwise toggle on completion
      if (ev_setup)          st_n.pid = 1'b1;
      else if (ev_xfer_ok)   st_n.pid = ~st.pid;
      // setup tracking: set events outrank the read-clear
      if (ev_setup)          st_n.setup = 1'b1;
      else if (rd_clr)       st_n.setup = 1'b0;
      if (ev_setup && st.setup) st_n.ovr = 1'b1;
      else if (rd_clr)          st_n.ovr = 1'b0;
      if (ev_buf_swap)       st_n.cpubuf = ~st.cpubuf;
      st_n.rsvd = 1'b0;
      irq_n = irq;
      if (ev_setup || ev_xfer_ok) irq_n = 1'b1;
      else if (rd_clr)            irq_n = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= '0;
         irq <= 1'b0;
      end else begin
         st  <= st_n;
         irq <= irq_n;
      end
   end

endmodule

// File: rtl/ep_status_bank.sv
module ep_status_bank
   import ep_stat_pkg::*;
#(
   parameter int NUM_EP   = 16,
   parameter int CMD_BASE = 8'h50,
   parameter int DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hp_wr,
   input  logic              hp_rd,
   input  logic              hp_a0,
   input  logic [7:0]        hp_cmd,
   output logic [DATA_W-1:0] hp_rdata,
   input  logic [NUM_EP-1:0] ev_stall,
   input  logic [NUM_EP-1:0] ev_unstall,
   input  logic [NUM_EP-1:0] ev_setup,
   input  logic [NUM_EP-1:0] ev_xfer_ok,
   input  logic [NUM_EP-1:0] ev_fill_pri,
   input  logic [NUM_EP-1:0] ev_fill_sec,
   input  logic [NUM_EP-1:0] ev_empty_pri,
   input  logic [NUM_EP-1:0] ev_empty_sec,
   input  logic [NUM_EP-1:0] ev_buf_swap,
   output logic [NUM_EP-1:0] irq
);
   localparam int SEL_W = $clog2(NUM_EP);

   if (NUM_EP < 2 || NUM_EP > 128) begin : g_bad_ep
      $error("ep_status_bank: NUM_EP out of range");
   end
   if (CMD_BASE < 0 || CMD_BASE + NUM_EP > 256) begin : g_bad_base
      $error("ep_status_bank: command window exceeds one byte");
   end
   if (DATA_W < STAT_W) begin : g_bad_dw
      $error("ep_status_bank: DATA_W narrower than status byte");
   end

   logic [SEL_W-1:0]          sel;
   logic                      data_rd;
   logic                      rd_fire;
   ep_stat_t                  st [NUM_EP];
   logic [NUM_EP*STAT_W-1:0]  st_flat;
   ep_stat_t                  rd_byte;

   ep_cmd_decode #(
      .NUM_EP   (NUM_EP),
      .CMD_BASE (CMD_BASE)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .hp_wr   (hp_wr),
      .hp_rd   (hp_rd),
      .hp_a0   (hp_a0),
      .hp_cmd  (hp_cmd),
      .sel     (sel),
      .data_rd (data_rd),
      .rd_fire (rd_fire)
   );

   for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
      logic clr;
      assign clr = rd_fire && (sel == SEL_W'(k));
      ep_stat_cell u_cell (
         .clk          (clk),
         .rst_n        (rst_n),
         .ev_stall     (ev_stall[k]),
         .ev_unstall   (ev_unstall[k]),
         .ev_setup     (ev_setup[k]),
         .ev_xfer_ok   (ev_xfer_ok[k]),
         .ev_fill_pri  (ev_fill_pri[k]),
         .ev_fill_sec  (ev_fill_sec[k]),
         .ev_empty_pri (ev_empty_pri[k]),
         .ev_empty_sec (ev_empty_sec[k]),
         .ev_buf_swap  (ev_buf_swap[k]),
         .rd_clr       (clr),
         .st           (st[k]),
         .irq          (irq[k])
      );
      assign st_flat[k*STAT_W +: STAT_W] = st[k];
   end

   assign rd_byte = rd_fire ? st[sel] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)       hp_rdata <= '0;
      else if (data_rd) hp_rdata <= DATA_W'(rd_byte);
   end

endmodule

// File: rtl/ep_status_chk.sv
module ep_status_chk #(
   parameter int NUM_EP = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hp_wr,
   input logic              hp_rd,
   input logic              hp_a0,
   input logic [DATA_W-1:0] hp_rdata,
   input logic [NUM_EP-1:0] ev_stall,
   input logic [NUM_EP-1:0] ev_setup,
   input logic [NUM_EP-1:0] ev_xfer_ok,
   input logic [NUM_EP-1:0] ev_fill_pri,
   input logic [NUM_EP-1:0] irq,
   input logic [NUM_EP*8-1:0] st_flat
);
   logic rd_ph;
   assign rd_ph = hp_rd && !hp_a0 && !hp_wr;

   // R10: back-to-back data reads, the second finds no selection
   a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ph && $past(rd_ph)) |=> (hp_rdata == '0));

   for (genvar k = 0; k < NUM_EP; k++) begin : g_k
      a_r8_irq_on_event: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_setup[k] || ev_xfer_ok[k]) |=> irq[k]);
      a_r4_stall_set: assert property (@(posedge clk) disable iff (!rst_n)
         ev_stall[k] |=> st_flat[k*8+7]);
      a_r5_setup_unstall: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_setup[k] && !ev_stall[k]) |=> (!st_flat[k*8+7] && st_flat[k*8+4]
                                            && st_flat[k*8+2]));
      a_r7_fill_pri: assert property (@(posedge clk) disable iff (!rst_n)
         ev_fill_pri[k] |=> st_flat[k*8+5]);
   end

endmodule

bind ep_status_bank ep_status_chk #(
   .NUM_EP (NUM_EP),
   .DATA_W (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hp_wr       (hp_wr),
   .hp_rd       (hp_rd),
   .hp_a0       (hp_a0),
   .hp_rdata    (hp_rdata),
   .ev_stall    (ev_stall),
   .ev_setup    (ev_setup),
   .ev_xfer_ok  (ev_xfer_ok),
   .ev_fill_pri (ev_fill_pri),
   .irq         (irq),
   .st_flat     (st_flat)
);

// File: tb/ep_status_bank_tb.sv
module ep_status_bank_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hp_wr = 0, hp_rd = 0, hp_a0 = 0;
   logic [7:0] hp_cmd = '0;
   logic [15:0] hp_rdata;
   logic [N-1:0] ev_stall = '0, ev_unstall = '0, ev_setup = '0, ev_xfer_ok = '0;
   logic [N-1:0] ev_fill_pri = '0, ev_fill_sec = '0, ev_empty_pri = '0;
   logic [N-1:0] ev_empty_sec = '0, ev_buf_swap = '0;
   logic [N-1:0] irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   ep_status_bank u_dut (.*);

   // behavioural reference
   bit m_stall[N], m_fs[N], m_fp[N], m_pid[N], m_ovr[N], m_stp[N], m_cpb[N], m_irq[N];
   bit m_armed;
   int m_sel;
   int m_rdata;
   int errors = 0, checks = 0;
   string cur_req = "R1";

   function automatic int pack(int e);
      return (int'(m_stall[e]) << 7) | (int'(m_fs[e]) << 6) | (int'(m_fp[e]) << 5) |
             (int'(m_pid[e]) << 4) | (int'(m_ovr[e]) << 3) | (int'(m_stp[e]) << 2) |
             (int'(m_cpb[e]) << 1);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_step();
      int clr = -1;
      if (hp_wr && hp_a0) begin
         m_armed = (hp_cmd >= 8'h50 && hp_cmd <= 8'h5F);
         if (m_armed) m_sel = int'(hp_cmd) - 'h50;
      end else if (hp_rd && !hp_a0) begin
         m_rdata = m_armed ? pack(m_sel) : 0;
         if (m_armed) clr = m_sel;
         m_armed = 0;
      end
      for (int e = 0; e < N; e++) begin
         bit s = ev_setup[e];
         bit c = (clr == e);
         if (ev_stall[e]) m_stall[e] = 1;
         else if (ev_unstall[e] || s) m_stall[e] = 0;
         if (ev_fill_pri[e]) m_fp[e] = 1; else if (ev_empty_pri[e]) m_fp[e] = 0;
         if (ev_fill_sec[e]) m_fs[e] = 1; else if (ev_empty_sec[e]) m_fs[e] = 0;
         if (s) m_pid[e] = 1; else if (ev_xfer_ok[e]) m_pid[e] = !m_pid[e];
         if (s && m_stp[e]) m_ovr[e] = 1; else if (c) m_ovr[e] = 0;
         if (s) m_stp[e] = 1; else if (c) m_stp[e] = 0;
         if (ev_buf_swap[e]) m_cpb[e] = !m_cpb[e];
         if (s || ev_xfer_ok[e]) m_irq[e] = 1; else if (c) m_irq[e] = 0;
      end
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk({cur_req, " rdata"}, int'(hp_rdata), m_rdata);
      for (int e = 0; e < N; e++) chk({cur_req, " irq"}, int'(irq[e]), int'(m_irq[e]));
      hp_wr = 0; hp_rd = 0; hp_a0 = 0; hp_cmd = '0;
      ev_stall = '0; ev_unstall = '0; ev_setup = '0; ev_xfer_ok = '0;
      ev_fill_pri = '0; ev_fill_sec = '0; ev_empty_pri = '0; ev_empty_sec = '0;
      ev_buf_swap = '0;
   endtask

   task automatic cmd(input logic [7:0] code);
      hp_wr = 1; hp_a0 = 1; hp_cmd = code;
      tick();
   endtask

   task automatic rd_expect(input string req, input int exp);
      hp_rd = 1; hp_a0 = 0;
      tick();
      chk(req, int'(hp_rdata), exp);
   endtask

   task automatic read_ep(input int e, input string req, input int exp);
      cmd(8'(8'h50 + e));
      rd_expect(req, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      m_armed = 0; m_sel = 0; m_rdata = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      cur_req = "R1";
      chk("R1 rdata", int'(hp_rdata), 0);
      chk("R1 irq", int'(irq), 0);
      read_ep(0, "R1 ep0 status", 'h00);

      // R4 on control OUT (index 0)
      cur_req = "R4";
      ev_stall[0] = 1; tick();
      read_ep(0, "R4 stall set R3 bit7", 'h80);
      ev_unstall[0] = 1; tick();
      read_ep(0, "R4 unstall", 'h00);
      ev_stall[0] = 1; ev_unstall[0] = 1; tick();
      read_ep(0, "R4 stall wins", 'h80);

      // R5 setup auto-unstall on index 5
      cur_req = "R5";
      ev_stall[5] = 1; tick();
      ev_setup[5] = 1; tick();
      chk("R8 irq after setup", int'(irq[5]), 1);
      read_ep(5, "R5 setup unstall, pid, setup flag", 'h14);
      chk("R8 irq cleared by read", int'(irq[5]), 0);
      rd_expect("R10 second read", 'h00);
      ev_setup[5] = 1; tick();
      ev_setup[5] = 1; tick();
      read_ep(5, "R5 overwrite", 'h1C);
      read_ep(5, "R8 setup/ovr cleared", 'h10);

      // R6 PID toggling
      cur_req = "R6";
      ev_xfer_ok[5] = 1; tick();
      read_ep(5, "R6 toggle to 0", 'h00);
      ev_xfer_ok[5] = 1; tick();
      ev_xfer_ok[9] = 1; tick();
      read_ep(5, "R6 toggle to 1", 'h10);
      chk("R8 other ep untouched", int'(irq[9]), 1);

      // R7 buffer flags on index 15
      cur_req = "R7";
      ev_fill_pri[15] = 1; tick();
      ev_fill_sec[15] = 1; tick();
      read_ep(15, "R7 both full", 'h60);
      ev_empty_pri[15] = 1; tick();
      read_ep(15, "R7 primary emptied", 'h40);
      ev_fill_sec[15] = 1; ev_empty_sec[15] = 1; tick();
      read_ep(15, "R7 fill wins", 'h40);
      ev_empty_sec[15] = 1; tick();
      read_ep(15, "R7 secondary emptied", 'h00);

      // R9 invalid codes
      cur_req = "R9";
      ev_stall[3] = 1; tick();
      cmd(8'h53); cmd(8'h4F);
      rd_expect("R9 below window", 'h00);
      cmd(8'h60);
      rd_expect("R9 above window", 'h00);
      rd_expect("R9 no selection", 'h00);
      chk("R9 irq9 kept", int'(irq[9]), 1);
      read_ep(3, "R9 state intact", 'h80);

      // R8 set wins over read-clear
      cur_req = "R8";
      cmd(8'h59);
      hp_rd = 1; ev_xfer_ok[9] = 1; tick();
      chk("R8 set wins", int'(irq[9]), 1);
      read_ep(9, "R8 status", 'h00);
      chk("R8 cleared", int'(irq[9]), 0);

      // R11 and R2 on control IN
      cur_req = "R11";
      ev_buf_swap[1] = 1; tick();
      read_ep(1, "R11 swap R2 index1", 'h02);
      ev_buf_swap[1] = 1; tick();
      read_ep(1, "R11 swap back", 'h00);

      cur_req = "R2";
      for (int e = 0; e < N; e++) begin
         ev_fill_pri[e] = (e % 3 == 0); ev_buf_swap[e] = (e % 2 == 1);
      end
      tick();
      for (int e = 0; e < N; e++) read_ep(e, "R2 per-endpoint map", pack(e));
      for (int r = 0; r < 3; r++) tick();
      chk("R2 rdata holds", int'(hp_rdata), pack(15));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule